// File: doc/BRIEF.md
# Link Quality Score Keeper

This block keeps a small score that rates the health of a serial position-encoder link on the master side. Every clock cycle the protocol decoder hands it a vector of single-cycle event pulses. Some pulses report good news, such as a correct synchronisation or a correct CRC in the safety channel. The others report faults, and each fault type carries its own penalty. The block adds all weights that are active in a cycle to the current score and applies one clamp to the range 0 to 15. It keeps a sticky low-quality warning. When the score would land on zero, it emits a one-cycle forced protocol reset request and restarts the score from its initial value.

Software and neighbouring logic read the result through a read-only status byte. It holds a link-established bit, three reserved zero bits and the 4-bit score. Every output is a plain registered control or status signal. The block has no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `link_qual_mon`

## Requirements
- R1: Event input bits carry these penalties when high: bit 0 safety-channel sync error on the final byte −4, bit 1 safety-channel sync error on bytes one to seven −6, bit 2 signal strength under 2 −4, bit 3 bad encoding in the parameter/sensor-hub channels −1, bit 4 bad encoding in the process-data channel −2, bit 5 unknown special character −2, bit 6 any safety channel 1 error −6, bit 7 any safety channel 2 error −8.
- R2: Event bit 8 (correct safety-channel sync) and event bit 9 (correct safety-channel CRC) each add +1.
- R3: All weights active in one cycle are summed with the current score in a signed intermediate, and the result is clamped once. It never exceeds 15, and 15 is held while only positive events arrive.
- R4: The score reads 0 while reset is held. On the first clock edge after reset is released it loads 8, and events in that cycle are ignored.
- R5: The warning output is set on the same edge that loads a score below 14. It stays set until the clear input is high on an edge where the loaded score is 14 or more. A set condition wins over the clear.
- R6: When the clamped result is 0, the score is reloaded to 8 instead, and the forced-reset output is high for exactly one cycle.
- R7: Status byte layout: bit 7 is the link bit, bits 6 to 4 read 0, and bits 3 to 0 hold the score. The whole byte is 0 during reset. The byte has no write path.
- R8: The link bit is the link-up input registered by one edge. It is forced to 0 in the cycle in which the forced-reset output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 10 | Event pulses, one bit per event type (see R1, R2) |
| link_up_i | input | 1 | Link established indication from the link layer |
| warn_clr_i | input | 1 | Clears the sticky warning |
| score_o | output | 4 | Current quality score |
| warn_o | output | 1 | Sticky low-quality warning |
| prst_o | output | 1 | One-cycle forced protocol reset request |
| status_o | output | 8 | Read-only status byte |

## Verification
Every result is registered once: the score, the warning, the reset pulse and the link bit all change on the first rising edge after the inputs they depend on are presented, with no further pipeline. The bench changes inputs on the falling edge, waits for the next rising edge and samples one nanosecond later, so each check sees exactly the response to the one stimulus just applied. The reset-release cycle is the only exception: the load to 8 takes that edge and the events presented with it are discarded, and the directed tests check this separately.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
  localparam int NUM_EV = 10;
  localparam int SUM_W  = 8;
  typedef logic signed [SUM_W-1:0] wt_t;

  // index = event bit position
  localparam wt_t EV_WT [NUM_EV] = '{
    -8'sd4,  // 0 sync error, final safety byte
    -8'sd6,  // 1 sync error, safety bytes one..seven
    -8'sd4,  // 2 weak signal
    -8'sd1,  // 3 encoding, parameter / sensor-hub
    -8'sd2,  // 4 encoding, process data
    -8'sd2,  // 5 unknown special character
    -8'sd6,  // 6 safety channel 1 error
    -8'sd8,  // 7 safety channel 2 error
     8'sd1,  // 8 safety sync good
     8'sd1   // 9 safety CRC good
  };
endpackage

// File: rtl/lqm_weight_sum.sv
module lqm_weight_sum
  import lqm_pkg::*;
(
  input  logic [NUM_EV-1:0] ev,
  output wt_t               delta
);
  always_comb begin
    delta = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (ev[i]) delta = delta + EV_WT[i];
    end
  end
endmodule

// File: rtl/lqm_score.sv
module lqm_score
  import lqm_pkg::*;
#(
  parameter int SCORE_W    = 4,
  parameter int SCORE_MAX  = 15,
  parameter int SCORE_INIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wt_t                delta,
  output logic [SCORE_W-1:0] score_q,
  output logic [SCORE_W-1:0] score_nxt,
  output logic               fire_nxt,
  output logic               prst_q
);
  localparam logic [SCORE_W-1:0] INIT_V = SCORE_W'(SCORE_INIT);
  localparam logic [SCORE_W-1:0] MAX_V  = SCORE_W'(SCORE_MAX);
  localparam wt_t                MAX_S  = wt_t'(SCORE_MAX);

  logic init_q;
  wt_t  sum;

  assign sum = wt_t'({{(SUM_W-SCORE_W){1'b0}}, score_q}) + delta;

  always_comb begin
    fire_nxt  = 1'b0;
    score_nxt = INIT_V;
    if (init_q) begin
      if (sum <= 0) begin
        fire_nxt  = 1'b1;
        score_nxt = INIT_V;
      end else if (sum > MAX_S) begin
        score_nxt = MAX_V;
      end else begin
        score_nxt = sum[SCORE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      score_q <= '0;
      init_q  <= 1'b0;
      prst_q  <= 1'b0;
    end else begin
      score_q <= score_nxt;
      init_q  <= 1'b1;
      prst_q  <= fire_nxt;
    end
  end
endmodule

// File: rtl/lqm_flags.sv
module lqm_flags #(
  parameter int SCORE_W  = 4,
  parameter int WARN_LVL = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCORE_W-1:0] score_nxt,
  input  logic               fire_nxt,
  input  logic               link_up,
  input  logic               warn_clr,
  output logic               warn_q,
  output logic               link_q
);
  localparam logic [SCORE_W-1:0] WARN_V = SCORE_W'(WARN_LVL);

  logic warn_set;
  assign warn_set = score_nxt < WARN_V;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      link_q <= 1'b0;
    end else begin
      warn_q <= warn_set | (warn_q & ~warn_clr);
      link_q <= link_up & ~fire_nxt;
    end
  end
endmodule

// File: rtl/link_qual_mon.sv
module link_qual_mon
  import lqm_pkg::*;
#(
  parameter int SCORE_W    = 4,
  parameter int SCORE_MAX  = 15,
  parameter int SCORE_INIT = 8,
  parameter int WARN_LVL   = 14,
  parameter int STAT_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EV-1:0]  ev_i,
  input  logic               link_up_i,
  input  logic               warn_clr_i,
  output logic [SCORE_W-1:0] score_o,
  output logic               warn_o,
  output logic               prst_o,
  output logic [STAT_W-1:0]  status_o
);
  localparam int RSV_W = STAT_W - 1 - SCORE_W;

  wt_t                delta;
  logic [SCORE_W-1:0] score_nxt;
  logic               fire_nxt;
  logic               link_q;

  lqm_weight_sum u_sum (.ev(ev_i), .delta(delta));

  lqm_score #(
    .SCORE_W(SCORE_W), .SCORE_MAX(SCORE_MAX), .SCORE_INIT(SCORE_INIT)
  ) u_score (
    .clk(clk), .rst_n(rst_n), .delta(delta),
    .score_q(score_o), .score_nxt(score_nxt),
    .fire_nxt(fire_nxt), .prst_q(prst_o)
  );

  lqm_flags #(.SCORE_W(SCORE_W), .WARN_LVL(WARN_LVL)) u_flags (
    .clk(clk), .rst_n(rst_n), .score_nxt(score_nxt), .fire_nxt(fire_nxt),
    .link_up(link_up_i), .warn_clr(warn_clr_i),
    .warn_q(warn_o), .link_q(link_q)
  );

  assign status_o = {link_q, {RSV_W{1'b0}}, score_o};
endmodule

// File: rtl/lqm_chk.sv
module lqm_chk #(
  parameter int SCORE_W = 4,
  parameter int STAT_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [9:0]         ev_i,
  input logic               warn_clr_i,
  input logic [SCORE_W-1:0] score_o,
  input logic               warn_o,
  input logic               prst_o,
  input logic [STAT_W-1:0]  status_o
);
  AST_PRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |=> !prst_o); // R6
  AST_PRST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |-> score_o == SCORE_W'(8)); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_W-2:SCORE_W] == '0); // R7
  AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |-> !status_o[STAT_W-1]); // R8
  AST_WARN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_o && !warn_clr_i) |=> warn_o); // R5
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i == 10'h100 && score_o != '0 && score_o < SCORE_W'(15))
      |=> score_o == $past(score_o) + SCORE_W'(1)); // R2
  AST_NO_ZERO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (score_o != '0) |=> score_o != '0); // R4
endmodule

bind link_qual_mon lqm_chk #(.SCORE_W(SCORE_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .warn_clr_i(warn_clr_i),
  .score_o(score_o), .warn_o(warn_o), .prst_o(prst_o), .status_o(status_o)
);

// File: tb/tb_link_qual_mon.sv
module tb_link_qual_mon;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] ev_i;
  logic       link_up_i;
  logic       warn_clr_i;
  logic [3:0] score_o;
  logic       warn_o;
  logic       prst_o;
  logic [7:0] status_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  link_qual_mon dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .link_up_i(link_up_i),
    .warn_clr_i(warn_clr_i), .score_o(score_o), .warn_o(warn_o),
    .prst_o(prst_o), .status_o(status_o)
  );

  // {ev[16:7], clr[6], score[5:2], warn[1], prst[0]}
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {10'h300, 1'b0, 4'd10, 1'b1, 1'b0},  // R2 +2
    {10'h300, 1'b0, 4'd12, 1'b1, 1'b0},
    {10'h300, 1'b0, 4'd14, 1'b1, 1'b0},
    {10'h300, 1'b1, 4'd15, 1'b0, 1'b0},  // R3 clamp, R5 clear
    {10'h100, 1'b0, 4'd15, 1'b0, 1'b0},  // R3 saturate
    {10'h008, 1'b0, 4'd14, 1'b0, 1'b0},  // R1 -1, R5 14 no warn
    {10'h008, 1'b0, 4'd13, 1'b1, 1'b0},  // R5 set below 14
    {10'h300, 1'b0, 4'd15, 1'b1, 1'b0},  // R5 sticky
    {10'h000, 1'b1, 4'd15, 1'b0, 1'b0},
    {10'h080, 1'b0, 4'd7,  1'b1, 1'b0},  // R1 -8
    {10'h001, 1'b0, 4'd3,  1'b1, 1'b0},  // R1 -4
    {10'h200, 1'b0, 4'd4,  1'b1, 1'b0},  // R2 +1
    {10'h082, 1'b0, 4'd8,  1'b1, 1'b1},  // R6 -14 -> zero
    {10'h000, 1'b0, 4'd8,  1'b1, 1'b0},  // R6 one cycle
    {10'h3FF, 1'b0, 4'd8,  1'b1, 1'b1},  // R3 all events -31
    {10'h000, 1'b0, 4'd8,  1'b1, 1'b0},
    {10'h030, 1'b0, 4'd4,  1'b1, 1'b0},  // R1 -2 -2
    {10'h004, 1'b0, 4'd8,  1'b1, 1'b1}   // R1 -4 to zero, R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] ev, input logic clr);
    @(negedge clk);
    ev_i = ev;
    warn_clr_i = clr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_i = '0; link_up_i = 1'b1; warn_clr_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset status", status_o, 8'h00);
    chk("R4 reset score", score_o, 4'd0);
    chk("R5 reset warn", warn_o, 1'b0);
    chk("R6 reset prst", prst_o, 1'b0);

    // release with an event pending: must be ignored (R4)
    @(negedge clk);
    rst_n = 1'b1;
    ev_i = 10'h080;
    @(posedge clk);
    #1;
    chk("R4 init to 8", score_o, 4'd8);
    chk("R5 warn at init", warn_o, 1'b1);
    chk("R8 link bit", status_o[7], 1'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16:7], VEC[i][6]);
      chk("R1/R3 score", score_o, VEC[i][5:2]);
      chk("R5 warn", warn_o, VEC[i][1]);
      chk("R6 prst", prst_o, VEC[i][0]);
      chk("R7/R8 status", status_o, {~VEC[i][0], 3'b000, VEC[i][5:2]});
    end

    // R5: clear with low score loses to set
    step(10'h000, 1'b1);
    chk("R5 set beats clear", warn_o, 1'b1);

    // R1: bit 6 alone -6, from 8 to 2
    step(10'h040, 1'b0);
    chk("R1 sc1 error", score_o, 4'd2);
    // R1: bit 1 alone -6 to zero -> reload
    step(10'h002, 1'b0);
    chk("R6 reload", score_o, 4'd8);
    chk("R6 pulse", prst_o, 1'b1);

    // R8: link follows input with one edge delay
    @(negedge clk);
    link_up_i = 1'b0;
    ev_i = '0;
    #1;
    chk("R8 link not yet", status_o[7], 1'b0);
    @(posedge clk);
    #1;
    chk("R8 link low", status_o[7], 1'b0);
    step(10'h000, 1'b0);
    chk("R7 status layout", status_o, {1'b0, 3'b000, 4'd8});

    // R4: reset mid-run returns to zero, then 8
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R7 mid reset status", status_o, 8'h00);
    chk("R5 mid reset warn", warn_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ev_i = 10'h300;
    @(posedge clk);
    #1;
    chk("R4 reinit ignores events", score_o, 4'd8);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule